// File: doc/BRIEF.md
# Masked Single-Lane Vector Arithmetic Unit

This block is one lane of a vector execution unit. A command names an operation, a destination vector register, up to two source vector registers, an optional scalar operand, an element count and a mask-enable bit. Once it accepts a command, the unit reads one element pair per clock from an external vector register file, through two combinational read ports indexed by element number. It sends each element through a fixed-latency pipeline and writes the result back through a single element write port. The same result appears on a forwarding port in the cycle it is written, so a dependent unit can chain on it element by element without waiting for the whole vector.

The unit supports wrap-around add, subtract and multiply in two forms: vector-vector, and vector-scalar, where the scalar replaces the second operand for every element. An equality compare fills a per-element mask register instead of writing a vector. When a command is masked, elements whose mask bit is clear still take their issue slot but are not written. The mask register can also be loaded whole from a wide scalar value. `busy` covers a command from acceptance to its last writeback, and `done` marks its end.

Top module: `vfu_masked_lane`

## Requirements
- R1: Operation codes are ADD=0, SUB=1, MUL=2. Each element i below the effective length is written to the destination register as a[i]+b[i], a[i]-b[i] or the low 16 bits of the signed product a[i]*b[i]. All arithmetic wraps modulo 2^16.
- R2: Codes ADDS=3, SUBS=4 and MULS=5 use `cmd_scalar` in place of b[i] for every element, so each element computes a[i] op scalar.
- R3: Code CMPEQ=6 sets mask bit i to 1 when a[i]==b[i] and to 0 otherwise, for each i below the effective length. Mask bits at or above the length keep their value. A compare writes no vector element.
- R4: When `cmd_masked` is 1, element i is written only if mask bit i (bit position i of `mask_q`) is 1.
- R5: Exactly one element issues per cycle, masked-off elements included. With acceptance at clock edge A, element i is written in the cycle after edge A+i+LAT, and `done` is high in the cycle after edge A+n+LAT.
- R6: LAT is 6 for ADD, SUB, ADDS, SUBS and CMPEQ, and 7 for MUL and MULS.
- R7: `busy` is high from the cycle after acceptance until the cycle of the last writeback. `done` is high for exactly one cycle, the cycle after that, with `busy` low.
- R8: `fwd_valid`, `fwd_idx` and `fwd_data` equal `wr_en`, `wr_idx` and `wr_data` in every cycle.
- R9: Code MSKLD=7, accepted while idle, copies `mask_src` into the mask register at the accepting edge. It does not raise `busy` or `done`.
- R10: `wr_ovf` flags signed 16-bit overflow of a written element. It is never high for an element that is not written.
- R11: A length above 64 is treated as 64. A length of 0 writes nothing, and `done` is high in the cycle after edge A+1.
- R12: A command presented while `busy` is high is ignored and has no effect on writes, timing or the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code (R1, R2, R3, R9) |
| cmd_dst | input | 2 | Destination vector register |
| cmd_src_a | input | 2 | First source vector register |
| cmd_src_b | input | 2 | Second source vector register |
| cmd_scalar | input | 16 | Scalar operand for vector-scalar forms |
| cmd_vl | input | 7 | Requested element count |
| cmd_masked | input | 1 | Apply the mask to writes |
| mask_src | input | 64 | Value for a direct mask load |
| rd_a_reg | output | 2 | Read port A register select |
| rd_b_reg | output | 2 | Read port B register select |
| rd_idx | output | 6 | Element index for both read ports |
| rd_a_data | input | 16 | Element read on port A |
| rd_b_data | input | 16 | Element read on port B |
| wr_en | output | 1 | Element write strobe |
| wr_reg | output | 2 | Register written |
| wr_idx | output | 6 | Element index written |
| wr_data | output | 16 | Element value written |
| wr_ovf | output | 1 | Overflow of the written element |
| fwd_valid | output | 1 | Forwarded result valid |
| fwd_idx | output | 6 | Forwarded element index |
| fwd_data | output | 16 | Forwarded element value |
| mask_q | output | 64 | Current mask register |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |

## Verification
A corrupted element counter or pipeline stage appears at the write port within six or seven cycles as a wrong index, a wrong value or a write in the wrong cycle. The scoreboard ties each expected write to an exact cycle, so a slip of one cycle is caught on the first element. A wrong latched mask appears either as a missing or extra masked write, or in `mask_q` at the cycle `done` rises. Sequencing faults move `done` or `busy` off their computed cycle, and that cycle is checked on every command.

// File: rtl/vfu_pkg.sv
package vfu_pkg;

  typedef enum logic [2:0] {
    VOP_ADD   = 3'd0,
    VOP_SUB   = 3'd1,
    VOP_MUL   = 3'd2,
    VOP_ADDS  = 3'd3,
    VOP_SUBS  = 3'd4,
    VOP_MULS  = 3'd5,
    VOP_CMPEQ = 3'd6,
    VOP_MSKLD = 3'd7
  } vop_e;

  function automatic logic op_is_mul(vop_e o);
    return (o == VOP_MUL) || (o == VOP_MULS);
  endfunction

  function automatic logic op_is_sub(vop_e o);
    return (o == VOP_SUB) || (o == VOP_SUBS);
  endfunction

  function automatic logic op_uses_scalar(vop_e o);
    return (o == VOP_ADDS) || (o == VOP_SUBS) || (o == VOP_MULS);
  endfunction

endpackage

// File: rtl/vfu_pipe.sv
module vfu_pipe #(
  parameter int W   = 8,
  parameter int LAT = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  logic [LAT-1:0] v_q;
  logic [W-1:0]   d_q [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q[0] <= 1'b0;
      d_q[0] <= '0;
    end else begin
      v_q[0] <= in_v;
      d_q[0] <= in_d;
    end
  end

  for (genvar k = 1; k < LAT; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q[k] <= 1'b0;
        d_q[k] <= '0;
      end else begin
        v_q[k] <= v_q[k-1];
        d_q[k] <= d_q[k-1];
      end
    end
  end

  assign out_v = v_q[LAT-1];
  assign out_d = d_q[LAT-1];
endmodule

// File: rtl/vfu_seq.sv
module vfu_seq #(
  parameter int MAXVL = 64,
  localparam int IW  = $clog2(MAXVL),
  localparam int VLW = $clog2(MAXVL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl,
  input  logic           fin,
  output logic           busy,
  output logic           done,
  output logic           issue_valid,
  output logic [IW-1:0]  issue_idx,
  output logic           issue_last
);
  logic [IW-1:0]  cnt_q;
  logic [VLW-1:0] len_q;
  logic           issuing_q;
  logic           zero_q;

  assign issue_valid = issuing_q;
  assign issue_idx   = cnt_q;
  assign issue_last  = issuing_q && (VLW'(cnt_q) == len_q - VLW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      issuing_q <= 1'b0;
      zero_q    <= 1'b0;
      cnt_q     <= '0;
      len_q     <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy      <= 1'b1;
        issuing_q <= (vl != '0);
        zero_q    <= (vl == '0);
        cnt_q     <= '0;
        len_q     <= vl;
      end else if (busy) begin
        if (issuing_q) begin
          cnt_q <= cnt_q + IW'(1);
          if (issue_last) issuing_q <= 1'b0;
        end
        if (fin || zero_q) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          zero_q <= 1'b0;
        end
      end
    end
  end

  a_r7_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy)) else $error("done without preceding busy");
  a_r12_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy) else $error("start accepted while busy");
  a_r5_consecutive_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && $past(issue_valid)) |-> (issue_idx == $past(issue_idx) + IW'(1)))
    else $error("issue index skipped");
  a_r5_issue_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> busy) else $error("issue outside busy");
endmodule

// File: rtl/vfu_masked_lane.sv
module vfu_masked_lane
  import vfu_pkg::*;
#(
  parameter int EW      = 16,
  parameter int NREG    = 4,
  parameter int MAXVL   = 64,
  parameter int ADD_LAT = 6,
  parameter int MUL_LAT = 7,
  localparam int IW  = $clog2(MAXVL),
  localparam int VLW = $clog2(MAXVL + 1),
  localparam int RW  = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [RW-1:0]    cmd_dst,
  input  logic [RW-1:0]    cmd_src_a,
  input  logic [RW-1:0]    cmd_src_b,
  input  logic [EW-1:0]    cmd_scalar,
  input  logic [VLW-1:0]   cmd_vl,
  input  logic             cmd_masked,
  input  logic [MAXVL-1:0] mask_src,
  output logic [RW-1:0]    rd_a_reg,
  output logic [RW-1:0]    rd_b_reg,
  output logic [IW-1:0]    rd_idx,
  input  logic [EW-1:0]    rd_a_data,
  input  logic [EW-1:0]    rd_b_data,
  output logic             wr_en,
  output logic [RW-1:0]    wr_reg,
  output logic [IW-1:0]    wr_idx,
  output logic [EW-1:0]    wr_data,
  output logic             wr_ovf,
  output logic             fwd_valid,
  output logic [IW-1:0]    fwd_idx,
  output logic [EW-1:0]    fwd_data,
  output logic [MAXVL-1:0] mask_q,
  output logic             busy,
  output logic             done
);
  typedef struct packed {
    logic          last;
    logic          wen;
    logic          cmp;
    logic          eq;
    logic          ovf;
    logic [IW-1:0] idx;
    logic [EW-1:0] data;
  } elem_t;
  localparam int PW = $bits(elem_t);

  // signed add/sub with overflow in the top bit of the result
  function automatic logic [EW:0] f_addsub(logic [EW-1:0] a, logic [EW-1:0] b, logic sub);
    logic [EW-1:0] r;
    logic          ov;
    r  = sub ? (a - b) : (a + b);
    ov = sub ? ((a[EW-1] != b[EW-1]) && (r[EW-1] != a[EW-1]))
             : ((a[EW-1] == b[EW-1]) && (r[EW-1] != a[EW-1]));
    return {ov, r};
  endfunction

  function automatic logic [EW:0] f_mul(logic [EW-1:0] a, logic [EW-1:0] b);
    logic signed [2*EW-1:0] p;
    logic                   ov;
    p  = $signed(a) * $signed(b);
    ov = !((&p[2*EW-1:EW-1]) || !(|p[2*EW-1:EW-1]));
    return {ov, p[EW-1:0]};
  endfunction

  vop_e           op_q;
  logic [RW-1:0]  dst_q, srca_q, srcb_q;
  logic [EW-1:0]  sc_q;
  logic           msk_q;
  logic [VLW-1:0] vl_eff;
  logic           start, ld_acc, fin;
  logic           issue_valid, issue_last;
  logic [IW-1:0]  issue_idx;
  elem_t          in_e, out_e;
  logic [PW-1:0]  add_d, mul_d;
  logic           add_v, mul_v, out_v;
  logic [EW-1:0]  b_op;
  logic [EW:0]    res;

  assign start  = cmd_valid && !busy && (vop_e'(cmd_op) != VOP_MSKLD);
  assign ld_acc = cmd_valid && !busy && (vop_e'(cmd_op) == VOP_MSKLD);
  assign vl_eff = (cmd_vl > VLW'(MAXVL)) ? VLW'(MAXVL) : cmd_vl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= VOP_ADD;
      dst_q  <= '0;
      srca_q <= '0;
      srcb_q <= '0;
      sc_q   <= '0;
      msk_q  <= 1'b0;
    end else if (start) begin
      op_q   <= vop_e'(cmd_op);
      dst_q  <= cmd_dst;
      srca_q <= cmd_src_a;
      srcb_q <= cmd_src_b;
      sc_q   <= cmd_scalar;
      msk_q  <= cmd_masked;
    end
  end

  vfu_seq #(.MAXVL(MAXVL)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl_eff), .fin(fin),
    .busy(busy), .done(done), .issue_valid(issue_valid),
    .issue_idx(issue_idx), .issue_last(issue_last)
  );

  assign rd_a_reg = srca_q;
  assign rd_b_reg = srcb_q;
  assign rd_idx   = issue_idx;

  always_comb begin
    b_op     = op_uses_scalar(op_q) ? sc_q : rd_b_data;
    res      = op_is_mul(op_q) ? f_mul(rd_a_data, b_op)
                               : f_addsub(rd_a_data, b_op, op_is_sub(op_q));
    in_e.last = issue_last;
    in_e.cmp  = (op_q == VOP_CMPEQ);
    in_e.eq   = (rd_a_data == rd_b_data);
    in_e.wen  = !in_e.cmp && (!msk_q || mask_q[issue_idx]);
    in_e.ovf  = res[EW] && in_e.wen;
    in_e.idx  = issue_idx;
    in_e.data = res[EW-1:0];
  end

  vfu_pipe #(.W(PW), .LAT(ADD_LAT)) u_pipe_add (
    .clk(clk), .rst_n(rst_n), .in_v(issue_valid && !op_is_mul(op_q)), .in_d(in_e),
    .out_v(add_v), .out_d(add_d)
  );
  vfu_pipe #(.W(PW), .LAT(MUL_LAT)) u_pipe_mul (
    .clk(clk), .rst_n(rst_n), .in_v(issue_valid && op_is_mul(op_q)), .in_d(in_e),
    .out_v(mul_v), .out_d(mul_d)
  );

  assign out_v = add_v || mul_v;
  assign out_e = mul_v ? elem_t'(mul_d) : elem_t'(add_d);
  assign fin   = out_v && out_e.last;

  always_ff @(posedge clk) begin
    if (!rst_n)                   mask_q <= '0;
    else if (ld_acc)              mask_q <= mask_src;
    else if (out_v && out_e.cmp)  mask_q[out_e.idx] <= out_e.eq;
  end

  assign wr_en     = out_v && out_e.wen;
  assign wr_reg    = dst_q;
  assign wr_idx    = out_e.idx;
  assign wr_data   = out_e.data;
  assign wr_ovf    = out_v && out_e.ovf;
  assign fwd_valid = wr_en;
  assign fwd_idx   = wr_idx;
  assign fwd_data  = wr_data;

  a_r4_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!msk_q || mask_q[wr_idx])) else $error("write to masked-off element");
  a_r10_ovf_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ovf |-> wr_en) else $error("overflow on unwritten element");
  a_r7_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_v |-> busy) else $error("pipeline output outside busy");
  a_r6_one_pipe: assert property (@(posedge clk) disable iff (!rst_n)
    !(add_v && mul_v)) else $error("both pipelines emit at once");
  a_r9_mask_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ld_acc && !out_v) |=> $stable(mask_q)) else $error("mask changed while idle");
endmodule

// File: tb/tb_vfu_masked_lane.sv
module tb_vfu_masked_lane;
  localparam int CLK_PERIOD = 10;
  localparam int OP_ADD = 0, OP_SUB = 1, OP_MUL = 2, OP_ADDS = 3, OP_SUBS = 4,
                 OP_MULS = 5, OP_CMP = 6, OP_MLD = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_dst = '0, cmd_src_a = '0, cmd_src_b = '0;
  logic [15:0] cmd_scalar = '0;
  logic [6:0]  cmd_vl = '0;
  logic        cmd_masked = 1'b0;
  logic [63:0] mask_src = '0;
  logic [1:0]  rd_a_reg, rd_b_reg, wr_reg;
  logic [5:0]  rd_idx, wr_idx, fwd_idx;
  logic [15:0] rd_a_data, rd_b_data, wr_data, fwd_data;
  logic        wr_en, wr_ovf, fwd_valid, busy, done;
  logic [63:0] mask_q;

  int cyc = 0, checks = 0, errors = 0;
  logic [15:0] rf  [4][64];
  logic [15:0] mdl [4][64];
  logic [63:0] exp_mask = '0;

  typedef struct {
    int          cyc;
    int          rg;
    int          idx;
    logic [15:0] data;
    logic        ovf;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (wr_en) rf[wr_reg][wr_idx] <= wr_data;
  assign rd_a_data = rf[rd_a_reg][rd_idx];
  assign rd_b_data = rf[rd_b_reg][rd_idx];

  vfu_masked_lane dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_dst(cmd_dst),
    .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b), .cmd_scalar(cmd_scalar), .cmd_vl(cmd_vl),
    .cmd_masked(cmd_masked), .mask_src(mask_src), .rd_a_reg(rd_a_reg), .rd_b_reg(rd_b_reg),
    .rd_idx(rd_idx), .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .wr_en(wr_en),
    .wr_reg(wr_reg), .wr_idx(wr_idx), .wr_data(wr_data), .wr_ovf(wr_ovf),
    .fwd_valid(fwd_valid), .fwd_idx(fwd_idx), .fwd_data(fwd_data), .mask_q(mask_q),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  function automatic logic [15:0] init_val(int r, int i);
    int v;
    case (r)
      0: v = i * 517 - 9000;
      1: v = (i % 2 == 0) ? (i * 517 - 9000) : (i * 3 + 1);
      2: v = 32000 - i * 9;
      default: v = -32000 + i * 11;
    endcase
    return v[15:0];
  endfunction

  // reference arithmetic on wide integers
  function automatic void calc(input int op, input logic [15:0] a, input logic [15:0] b,
                               output logic [15:0] r, output logic ov);
    longint sa, sb, x;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (op == OP_ADD || op == OP_ADDS)      x = sa + sb;
    else if (op == OP_SUB || op == OP_SUBS) x = sa - sb;
    else                                    x = sa * sb;
    ov = (x > 32767) || (x < -32768);
    r  = x[15:0];
  endfunction

  // monitor: pops expected writes and compares them in their cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        if (sb.size() == 0) begin
          check(1'b0, "R4", "unexpected write idx", longint'(wr_idx), -1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(cyc == e.cyc, "R5", {e.tag, " write cycle"}, cyc, e.cyc);
          check(int'(wr_reg) == e.rg && int'(wr_idx) == e.idx, e.tag, "write reg/idx",
                longint'({wr_reg, wr_idx}), longint'(e.rg * 64 + e.idx));
          check(wr_data == e.data, e.tag, "write data", wr_data, e.data);
          check(wr_ovf == e.ovf, "R10", "overflow flag", wr_ovf, e.ovf);
          check(fwd_valid && fwd_idx == wr_idx && fwd_data == e.data, "R8", "forward data",
                fwd_data, e.data);
        end
      end else begin
        if (fwd_valid) check(1'b0, "R8", "forward without write", 1, 0);
        if (wr_ovf)    check(1'b0, "R10", "overflow without write", 1, 0);
      end
    end
  end

  task automatic run_op(input int op, input int ra, input int rb, input int rd,
                        input logic [15:0] sc, input int vl, input bit msk,
                        input bit inject, input string tag);
    int n, lat, a_cyc, d_cyc;
    logic [15:0] wv [64];
    bit          we [64];
    logic [63:0] nmask;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_src_a = 2'(ra); cmd_src_b = 2'(rb);
    cmd_dst = 2'(rd); cmd_scalar = sc; cmd_vl = 7'(vl); cmd_masked = msk;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    a_cyc = cyc;
    check(busy == 1'b1, "R7", "busy after accept", busy, 1);
    n   = (vl > 64) ? 64 : vl;
    lat = (op == OP_MUL || op == OP_MULS) ? 7 : 6;
    nmask = exp_mask;
    for (int i = 0; i < 64; i++) we[i] = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic [15:0] a, b, r;
      logic        ov;
      a = mdl[ra][i];
      b = (op == OP_ADDS || op == OP_SUBS || op == OP_MULS) ? sc : mdl[rb][i];
      if (op == OP_CMP) begin
        nmask[i] = (a == b);
      end else if (!msk || exp_mask[i]) begin
        exp_t e;
        calc(op, a, b, r, ov);
        e.cyc = a_cyc + i + lat; e.rg = rd; e.idx = i; e.data = r; e.ovf = ov; e.tag = tag;
        sb.push_back(e);
        wv[i] = r; we[i] = 1'b1;
      end
    end
    d_cyc = (n == 0) ? a_cyc + 1 : a_cyc + n + lat;
    while (cyc < d_cyc) begin
      if (inject && cyc == a_cyc + 2) begin
        cmd_valid = 1'b1; cmd_op = 3'(OP_MLD); mask_src = '1;
      end else begin
        cmd_valid = 1'b0;
      end
      if (n > 0 && cyc == d_cyc - 1)
        check(busy == 1'b1 && done == 1'b0, "R7", "busy through last write", {busy, done}, 2'b10);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    check(done == 1'b1 && busy == 1'b0, (n == 0) ? "R11" : "R5", {tag, " done timing"},
          {busy, done}, 2'b01);
    for (int i = 0; i < 64; i++) if (we[i]) mdl[rd][i] = wv[i];
    exp_mask = nmask;
    check(mask_q == exp_mask, inject ? "R12" : "R3", "mask after command", mask_q, exp_mask);
    @(negedge clk);
    check(done == 1'b0, "R7", "done single cycle", done, 0);
  endtask

  task automatic load_mask(input logic [63:0] val);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(OP_MLD); mask_src = val;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    exp_mask = val;
    check(mask_q == val, "R9", "mask load value", mask_q, val);
    check(busy == 1'b0 && done == 1'b0, "R9", "mask load no busy", {busy, done}, 0);
    @(negedge clk);
    check(done == 1'b0, "R9", "mask load no done", done, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R5", "watchdog expired", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < 4; r++)
      for (int i = 0; i < 64; i++) begin
        rf[r][i]  = init_val(r, i);
        mdl[r][i] = init_val(r, i);
      end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && wr_en == 1'b0, "R7", "reset outputs",
          {busy, done, wr_en}, 0);
    check(mask_q == 64'd0, "R9", "reset mask", mask_q, 0);

    run_op(OP_ADD,  0, 1, 3, 16'd0,     8,   0, 0, "R1");
    run_op(OP_SUB,  0, 2, 3, 16'd0,     5,   0, 0, "R1");
    run_op(OP_MUL,  0, 1, 3, 16'd0,     64,  0, 0, "R6");
    run_op(OP_ADDS, 2, 0, 3, 16'd1000,  10,  0, 0, "R2");
    run_op(OP_SUBS, 3, 0, 1, 16'h7000,  6,   0, 0, "R2");
    run_op(OP_MULS, 0, 0, 3, 16'hFFFD,  12,  0, 0, "R2");
    run_op(OP_ADD,  2, 2, 3, 16'd0,     8,   0, 0, "R10");
    run_op(OP_CMP,  0, 1, 3, 16'd0,     64,  0, 0, "R3");
    run_op(OP_ADD,  0, 2, 3, 16'd0,     64,  1, 0, "R4");
    load_mask(64'h0000_0000_F0F0_00A5);
    run_op(OP_MULS, 3, 0, 2, 16'd5,     20,  1, 1, "R12");
    run_op(OP_CMP,  3, 3, 0, 16'd0,     3,   0, 0, "R3");
    run_op(OP_ADD,  0, 1, 3, 16'd0,     0,   0, 0, "R11");
    run_op(OP_SUB,  1, 0, 3, 16'd0,     100, 0, 0, "R11");
    load_mask(64'd0);
    run_op(OP_SUB,  0, 1, 2, 16'd0,     16,  1, 0, "R4");
    load_mask(64'h8000_0000_0000_0009);
    run_op(OP_MUL,  3, 1, 0, 16'd0,     64,  1, 0, "R4");
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R5", "writes outstanding", sb.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule